// File: doc/BRIEF.md
# Write-Once Lockable Watchdog Timer

This block is a watchdog timer with one 32-bit register on a plain write/read port. The first write after a hardware reset captures the whole configuration: a 12-bit reload count, a prescale select, a run select and a 2-bit action code. The same write locks the register and, if the run select is set, loads the down-counter and starts it. From then on the register cannot be changed. Any later write, whatever its data, is a kick that reloads the counter from the locked reload count.

The counter advances on a tick. The base tick comes on every second bus clock. With the prescale select set, only one base tick in `PRESCALE` advances the counter. When the counter runs out, the block raises either an interrupt or a reset request, chosen by the locked action code. That output stays high until the next kick or a hardware reset. Only the asynchronous reset or the synchronous clear can unlock the register.

Top module: `oncewdt`

## Requirements
- R1: After either reset, `rd_data` is zero and both `expire_irq` and `expire_rst` are low.
- R2: The first write stores `wr_data[15:0]` as the configuration: reload count in [11:0], prescale select in bit 12, run select in bit 13 and action code in [15:14]. From the next cycle, `rd_data` returns those 16 bits with bit 16 set as the lock flag and all other bits zero.
- R3: Once the register is locked, no write changes any bit of `rd_data`.
- R4: If the first write has bit 13 clear, the register still locks. Neither expiry output ever rises, including after later writes with bit 13 set.
- R5: With the prescale select clear, the expiry output rises at the 2·max(R,1)-th rising clock edge after the edge that samples the starting write, where R is the reload count. It is low at every edge before that. The counter never advances on two consecutive clocks.
- R6: With the prescale select set, the expiry output rises at the 2·PRESCALE·max(R,1)-th edge after the starting write.
- R7: While running, a write of any data reloads the counter and restarts the timing of R5/R6 from that write's edge. It also drops an active expiry output on the same edge.
- R8: Action code 2 routes expiry to `expire_irq`; any other code routes it to `expire_rst`. The two outputs are never high together.
- R9: Once raised, the expiry output stays high until a kick or a reset.
- R10: Both `rst_n` (asynchronous, active low) and `srst` (synchronous, active high) clear the lock and the configuration, so a new first write is accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous clear, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; bits [15:0] are taken only by the first write |
| rd_data | output | 32 | Locked configuration in [15:0], lock flag in bit 16 |
| expire_irq | output | 1 | Expiry interrupt (action code 2) |
| expire_rst | output | 1 | Expiry reset request (other action codes) |

## Verification
Each random case clears the block and writes a random reload count, prescale select and action code. It then measures the exact edge at which expiry appears, which tells a count that is off by one tick, or a wrong base or prescale rate, from a correct one. About half the cases kick at a random point before expiry and re-measure from the kick edge, with data chosen to differ from the locked word. This shows whether a kick only reloads or also changes the configuration. Directed cases cover a reload of zero, the full 4095 count, a first write with the run bit clear, holding after expiry, and unlocking through each reset.

// File: rtl/oncewdt_pkg.sv
package oncewdt_pkg;
  localparam int RELOAD_W = 12;
  localparam int DATA_W   = 32;
  localparam int LOCK_BIT = 16;
  localparam logic [1:0] ACT_IRQ = 2'd2;

  typedef struct packed {
    logic [1:0]          act;
    logic                run_en;
    logic                pre_en;
    logic [RELOAD_W-1:0] reload;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  function automatic cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
    cfg_t c;
    c = w[CFG_W-1:0];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] readback_word(input logic lock, input cfg_t c);
    logic [DATA_W-1:0] r;
    r = '0;
    r[CFG_W-1:0] = c;
    r[LOCK_BIT]  = lock;
    return r;
  endfunction

  function automatic logic routes_to_irq(input logic [1:0] a);
    return a == ACT_IRQ;
  endfunction
endpackage

// File: rtl/oncewdt_cfg.sv
module oncewdt_cfg
  import oncewdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_t              cfg,
  output logic              lock,
  output logic              start,
  output logic              kick
);
  cfg_t cfg_q;
  logic lock_q;
  cfg_t wr_cfg;
  logic unused_hi;

  assign wr_cfg    = cfg_from_word(wr_data);
  assign unused_hi = ^wr_data[DATA_W-1:CFG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      cfg_q  <= '0;
    end else if (srst) begin
      lock_q <= 1'b0;
      cfg_q  <= '0;
    end else if (wr_en && !lock_q) begin
      lock_q <= 1'b1;
      cfg_q  <= wr_cfg;
    end
  end

  assign start = wr_en && !lock_q && wr_cfg.run_en;
  assign kick  = wr_en && lock_q && cfg_q.run_en;
  assign cfg   = cfg_q;
  assign lock  = lock_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !srst) |=> (lock_q && $stable(cfg_q))); // R3
  AST_STOPPED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !cfg_q.run_en) |-> !kick); // R4
endmodule

// File: rtl/oncewdt_tick.sv
module oncewdt_tick #(
  parameter int PRESCALE = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic run,
  input  logic restart,
  input  logic pre_en,
  output logic step
);
  logic ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ph_q <= 1'b0;
    else if (srst || restart || !run) ph_q <= 1'b0;
    else                          ph_q <= ~ph_q;
  end

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] pcnt_q;
      logic          pre_wrap;
      assign pre_wrap = (pcnt_q == PW'(PRESCALE - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   pcnt_q <= '0;
        else if (srst || restart || !run) pcnt_q <= '0;
        else if (ph_q && pre_en)      pcnt_q <= pre_wrap ? '0 : pcnt_q + 1'b1;
      end
      assign step = run && !restart && ph_q && (!pre_en || pre_wrap);
    end else begin : g_nopre
      logic unused_pre;
      assign unused_pre = pre_en;
      assign step = run && !restart && ph_q;
    end
  endgenerate

  AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step); // R5
endmodule

// File: rtl/oncewdt_cnt.sv
module oncewdt_cnt
  import oncewdt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                srst,
  input  logic                load,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                step,
  output logic                expired
);
  logic [RELOAD_W-1:0] cnt_q;
  logic                exp_q;
  logic                last_step;

  assign last_step = step && !exp_q && (cnt_q <= RELOAD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (srst) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (load) begin
      cnt_q <= reload;
      exp_q <= 1'b0;
    end else if (last_step) begin
      cnt_q <= '0;
      exp_q <= 1'b1;
    end else if (step && !exp_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = exp_q;

  AST_EXPIRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_q && !load && !srst) |=> exp_q); // R9
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !exp_q); // R7
endmodule

// File: rtl/oncewdt.sv
module oncewdt
  import oncewdt_pkg::*;
#(
  parameter int PRESCALE = 16384
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        expire_irq,
  output logic        expire_rst
);
  cfg_t cfg;
  logic lock, start, kick, load, run, step, expired, to_irq;

  oncewdt_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(wr_en), .wr_data(wr_data),
    .cfg(cfg), .lock(lock), .start(start), .kick(kick)
  );

  assign load = start || kick;
  assign run  = lock && cfg.run_en;

  oncewdt_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .srst(srst), .run(run), .restart(load),
    .pre_en(cfg.pre_en), .step(step)
  );

  oncewdt_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .srst(srst), .load(load),
    .reload(start ? cfg_from_word(wr_data).reload : cfg.reload),
    .step(step), .expired(expired)
  );

  assign to_irq     = routes_to_irq(cfg.act);
  assign expire_irq = expired && to_irq;
  assign expire_rst = expired && !to_irq;
  assign rd_data    = readback_word(lock, cfg);

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(expire_irq && expire_rst)); // R8
  AST_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |-> (!expire_irq && !expire_rst && !step)); // R1
  AST_NO_STEP_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !step); // R4
endmodule

// File: tb/oncewdt_tb_top.sv
module oncewdt_tb_top;
  localparam int PRESC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srst = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        expire_irq, expire_rst;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  oncewdt #(.PRESCALE(PRESC)) dut_i (
    .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .expire_irq(expire_irq), .expire_rst(expire_rst)
  );

  function automatic int exp_edges(input int reload, input bit pre);
    int r;
    r = (reload < 1) ? 1 : reload;
    return 2 * r * (pre ? PRESC : 1);
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] w);
    return {15'd0, 1'b1, w[15:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic sync_clear();
    @(negedge clk); srst = 1'b1;
    @(negedge clk); srst = 1'b0;
  endtask

  task automatic outs_low(input string req);
    check(!expire_irq && !expire_rst, req, {expire_irq, expire_rst}, 0);
  endtask

  task automatic outs_fired(input string req, input logic [1:0] act);
    logic [1:0] e;
    e = (act == 2'd2) ? 2'b10 : 2'b01;
    check({expire_irq, expire_rst} == e, req, {expire_irq, expire_rst}, e);
  endtask

  // called at the negedge right after the starting/kick edge
  task automatic measure(input int n, input logic [1:0] act, input string req);
    repeat (n - 1) @(posedge clk);
    @(negedge clk); outs_low(req);
    @(posedge clk); @(negedge clk); outs_fired(req, act);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    outs_low("R1");
    check(rd_data == 0, "R1", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: first write with run bit clear
    wr(32'h0000_8005);
    check(rd_data == exp_read(32'h0000_8005), "R2", rd_data, exp_read(32'h0000_8005));
    wr(32'h0000_A005);
    repeat (200) @(negedge clk);
    outs_low("R4");
    check(rd_data == exp_read(32'h0000_8005), "R4", rd_data, exp_read(32'h0000_8005));

    // R10 sync clear unlocks
    sync_clear();
    check(rd_data == 0, "R10", rd_data, 0);

    // R5 reload zero, action 2 -> irq
    wr(32'h0000_A000);
    check(rd_data == exp_read(32'h0000_A000), "R2", rd_data, exp_read(32'h0000_A000));
    measure(exp_edges(0, 0), 2'd2, "R5");
    // R9 holds
    repeat (25) @(negedge clk);
    outs_fired("R9", 2'd2);
    // R7 kick clears on its edge and restarts
    wr(32'hFFFF_FFFF);
    outs_low("R7");
    check(rd_data == exp_read(32'h0000_A000), "R3", rd_data, exp_read(32'h0000_A000));
    measure(exp_edges(0, 0), 2'd2, "R7");

    // R10 async reset unlocks
    @(negedge clk); rst_n = 1'b0;
    #3;
    check(rd_data == 0, "R10", rd_data, 0);
    outs_low("R10");
    @(negedge clk); rst_n = 1'b1;

    // R5 full reload, action 0 -> reset request
    wr(32'h0000_2FFF);
    measure(exp_edges(4095, 0), 2'd0, "R5");
    check(!expire_irq, "R8", expire_irq, 0);

    // random cases
    for (int i = 0; i < 14; i++) begin
      int r, n, k;
      bit p;
      logic [1:0] a;
      logic [31:0] w, kd;
      sync_clear();
      check(rd_data == 0, "R10", rd_data, 0);
      r = $urandom_range(0, 20);
      p = $urandom_range(0, 1);
      a = 2'($urandom_range(0, 3));
      w = {$urandom} & 32'hFFFF_0000;
      w[15:0] = {a, 1'b1, p, 12'(r)};
      wr(w);
      check(rd_data == exp_read(w), "R2", rd_data, exp_read(w));
      n = exp_edges(r, p);
      if (n >= 3 && $urandom_range(0, 1) == 1) begin
        k = $urandom_range(1, n - 2);
        repeat (k) @(posedge clk);
        kd = ~w;
        wr(kd);
        check(rd_data == exp_read(w), "R3", rd_data, exp_read(w));
      end
      measure(n, a, p ? "R6" : "R5");
      outs_fired("R8", a);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule